// File: doc/BRIEF.md
# Two-Stage Watchdog Timer with Interrupt Pre-Warning

This block watches for a stalled processor. Software arms it by writing a nonzero limit into the timeout register. A counter then starts from zero on the register-bus clock. If software lets the counter reach that limit, the block escalates. In direct mode (interrupt enable clear), it fires a reset at once. In pre-warning mode (interrupt enable set), it first raises an interrupt and starts a second counter. It forces the reset only if software leaves that interrupt uncleared until the second counter reaches the acknowledge-window limit.

A fired reset drives the internal peripheral reset and the external system reset low together for a fixed number of clock cycles. After the pulse, the first counter, the second counter, the pending interrupt and the timeout register all return to zero, so the watchdog stays disarmed until software writes a new limit.

The controller has four states:
- `S_IDLE`: disarmed.
- `S_COUNT`: the first counter is running.
- `S_WARN`: the interrupt is pending and the second counter is running.
- `S_RESET`: the reset pulse is active.

It has these transitions:
- *arm* (`S_IDLE`→`S_COUNT`): a start write.
- *stop* (`S_COUNT`→`S_IDLE`): a zero write.
- *restart* (`S_COUNT`→`S_COUNT`): a different nonzero write.
- *warn* (`S_COUNT`→`S_WARN`): the limit is reached with the interrupt enabled.
- *fire* (`S_COUNT`→`S_RESET`): the limit is reached with the interrupt disabled.
- *acknowledge* (`S_WARN`→`S_COUNT`, or `S_WARN`→`S_IDLE` if the timeout register is zero): an interrupt clear.
- *expire* (`S_WARN`→`S_RESET`): the acknowledge window runs out.
- *disarm* (`S_RESET`→`S_IDLE`): the pulse ends.

Top module: `watchdog_escalator`

## Requirements
- R1: After reset, `irq` is 0, `peri_rst_n` and `sys_rst_n` are 1, and all four register offsets read 0.
- R2: The register map uses byte offsets on `bus_addr`, and a write needs `bus_addr[1:0]` = 0. Offset 0x0 is the timeout limit and 0x4 is the acknowledge-window limit; both are full-width read/write. Offset 0x8 is the interrupt enable: bit 0 is stored and the other bits read 0. At offset 0xC, a write with bit 0 = 1 clears the pending interrupt, and a read returns the pending flag in bit 0.
- R3: A timeout write with value T ≠ 0 different from the stored value restarts the first counter at zero. In direct mode, both resets go low on the (T+1)-th rising edge after the write edge.
- R4: Once fired, both reset outputs are low together for exactly PULSE_LEN (16) consecutive cycles, then return high.
- R5: After the pulse, the timeout register and the pending flag read 0, and no further reset occurs without a new arming write.
- R6: In pre-warning mode, `irq` rises on the (T+1)-th edge after the arming write, while both resets stay high.
- R7: If the interrupt is not cleared, both resets go low on the (W+1)-th edge after the edge that raised `irq`, where W is the acknowledge-window limit.
- R8: A clear write while the interrupt is pending drops `irq` on its edge and prevents the reset. The first counter restarts from zero, so `irq` rises again T+1 edges after the clear edge.
- R9: Writing 0 to the timeout register stops the count, and no interrupt or reset follows.
- R10: Rewriting the timeout register with a different nonzero value T2 while counting restarts the count, and the reset fires T2+1 edges after that write.
- R11: Rewriting the same nonzero value that is already stored leaves the running count undisturbed.
- R12: Register writes made while the reset pulse is active are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register-bus clock, which also runs both counters |
| rst_n | input | 1 | Asynchronous active-low reset of the block |
| bus_sel | input | 1 | Register access strobe for this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Byte offset of the register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, combinational from `bus_addr` |
| irq | output | 1 | Pre-warning interrupt, high while pending |
| peri_rst_n | output | 1 | Internal active-low peripheral reset |
| sys_rst_n | output | 1 | External active-low system reset |

## Verification
The bench builds the block with its default parameters: DATA_W = 32 and PULSE_LEN = 16. The full 16-cycle pulse is measured as it stands. Timeout and window limits between 3 and 8 bring every transition within a few tens of cycles: arming, restart, same-value rewrite, stop, warning, acknowledge, expiry and disarm. Each of these is timed to the exact edge on which the interrupt or the reset outputs change.

// File: rtl/wde_pkg.sv
package wde_pkg;

    localparam int ADDR_W = 4;

    typedef enum logic [1:0] {
        S_IDLE,
        S_COUNT,
        S_WARN,
        S_RESET
    } wde_state_t;

    localparam logic [1:0] IDX_TMO = 2'd0;
    localparam logic [1:0] IDX_WIN = 2'd1;
    localparam logic [1:0] IDX_EN  = 2'd2;
    localparam logic [1:0] IDX_CLR = 2'd3;

endpackage

// File: rtl/wde_regs.sv
module wde_regs
    import wde_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_sel,
    input  logic                 bus_wr,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [DATA_W-1:0]    bus_wdata,
    input  logic                 lock,
    input  logic                 disarm,
    input  logic                 pending,
    output logic [DATA_W-1:0]    tmo,
    output logic [DATA_W-1:0]    win,
    output logic                 irq_en,
    output logic                 tmo_start,
    output logic                 tmo_stop,
    output logic                 clr_req,
    output logic [DATA_W-1:0]    bus_rdata
);

    logic [1:0] idx;
    logic       wr_ok;

    assign idx   = bus_addr[3:2];
    assign wr_ok = bus_sel && bus_wr && !lock && (bus_addr[1:0] == 2'b00);

    // Events handed to the controller: only the timeout and clear registers steer it.
    assign tmo_start = wr_ok && (idx == IDX_TMO) && (bus_wdata != '0) && (bus_wdata != tmo);
    assign tmo_stop  = wr_ok && (idx == IDX_TMO) && (bus_wdata == '0);
    assign clr_req   = wr_ok && (idx == IDX_CLR) && bus_wdata[0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tmo    <= '0;
            win    <= '0;
            irq_en <= 1'b0;
        end else if (disarm) begin
            tmo <= '0;
        end else if (wr_ok) begin
            unique case (idx)
                IDX_TMO: tmo    <= bus_wdata;
                IDX_WIN: win    <= bus_wdata;
                IDX_EN:  irq_en <= bus_wdata[0];
                IDX_CLR: ;
                default: ;
            endcase
        end
    end

    always_comb begin
        unique case (idx)
            IDX_TMO: bus_rdata = tmo;
            IDX_WIN: bus_rdata = win;
            IDX_EN:  bus_rdata = {{(DATA_W-1){1'b0}}, irq_en};
            IDX_CLR: bus_rdata = {{(DATA_W-1){1'b0}}, pending};
            default: bus_rdata = '0;
        endcase
    end

    // R12: the pulse locks the register file
    p_locked_writes_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && lock) |=> ($stable(win) && $stable(irq_en)))
        else $error("write altered registers during reset pulse");

endmodule

// File: rtl/wde_ctrl.sv
module wde_ctrl
    import wde_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int PULSE_LEN = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] tmo,
    input  logic [DATA_W-1:0] win,
    input  logic              irq_en,
    input  logic              tmo_start,
    input  logic              tmo_stop,
    input  logic              clr_req,
    output logic              pending,
    output logic              lock,
    output logic              disarm,
    output logic              peri_rst_n,
    output logic              sys_rst_n
);

    localparam int               PC_W    = (PULSE_LEN > 2) ? $clog2(PULSE_LEN) : 1;
    localparam logic [PC_W-1:0]  PC_LAST = PC_W'(PULSE_LEN - 1);

    wde_state_t        state, state_n;
    logic [DATA_W-1:0] cnt, cnt_n;
    logic [DATA_W-1:0] cnt2, cnt2_n;
    logic [PC_W-1:0]   pc, pc_n;
    logic              pend_n;

    always_comb begin
        state_n = state;
        cnt_n   = cnt;
        cnt2_n  = cnt2;
        pc_n    = pc;
        pend_n  = pending;
        unique case (state)
            S_IDLE: begin
                if (tmo_start) begin
                    state_n = S_COUNT;
                    cnt_n   = '0;
                end
            end
            S_COUNT: begin
                if (tmo_stop) begin
                    state_n = S_IDLE;
                    cnt_n   = '0;
                end else if (tmo_start) begin
                    cnt_n = '0;
                end else if (cnt == tmo) begin
                    if (irq_en) begin
                        state_n = S_WARN;
                        pend_n  = 1'b1;
                        cnt2_n  = '0;
                    end else begin
                        state_n = S_RESET;
                        pc_n    = '0;
                    end
                end else begin
                    cnt_n = cnt + 1'b1;
                end
            end
            S_WARN: begin
                // An acknowledge on the expiry edge wins over the expiry.
                if (clr_req) begin
                    pend_n  = 1'b0;
                    cnt_n   = '0;
                    state_n = (tmo != '0) ? S_COUNT : S_IDLE;
                end else if (cnt2 == win) begin
                    state_n = S_RESET;
                    pc_n    = '0;
                end else begin
                    cnt2_n = cnt2 + 1'b1;
                end
            end
            S_RESET: begin
                if (pc == PC_LAST) begin
                    state_n = S_IDLE;
                    pend_n  = 1'b0;
                    cnt_n   = '0;
                    cnt2_n  = '0;
                end else begin
                    pc_n = pc + 1'b1;
                end
            end
            default: state_n = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= S_IDLE;
            cnt     <= '0;
            cnt2    <= '0;
            pc      <= '0;
            pending <= 1'b0;
        end else begin
            state   <= state_n;
            cnt     <= cnt_n;
            cnt2    <= cnt2_n;
            pc      <= pc_n;
            pending <= pend_n;
        end
    end

    always_comb begin
        lock       = (state == S_RESET);
        disarm     = (state == S_RESET) && (pc == PC_LAST);
        peri_rst_n = !lock;
        sys_rst_n  = !lock;
    end

    // R3: the first counter never overtakes the limit it is compared with
    p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_COUNT) |-> (cnt <= tmo))
        else $error("first counter beyond timeout limit");

    // R6: the warning stage always carries a pending interrupt
    p_warn_pending_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_WARN) |-> pending)
        else $error("warning stage without pending interrupt");

    // R8: an acknowledge drops the interrupt and averts the reset
    p_ack_averts_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_WARN && clr_req) |=> (!pending && state != S_RESET))
        else $error("acknowledge did not avert reset");

    // R9: a zero write stops the count
    p_stop_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_COUNT && tmo_stop) |=> (state == S_IDLE))
        else $error("zero write did not stop the count");

    // R4: the pulse is held until its last cycle
    p_pulse_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_RESET && pc != PC_LAST) |=> (state == S_RESET))
        else $error("reset pulse cut short");

    // R5: the end of the pulse disarms the watchdog
    p_disarm_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_RESET && pc == PC_LAST) |=> (state == S_IDLE && !pending && tmo == '0))
        else $error("watchdog not disarmed after pulse");

endmodule

// File: rtl/watchdog_escalator.sv
module watchdog_escalator
    import wde_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int PULSE_LEN = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq,
    output logic              peri_rst_n,
    output logic              sys_rst_n
);

    logic [DATA_W-1:0] tmo;
    logic [DATA_W-1:0] win;
    logic              irq_en;
    logic              tmo_start;
    logic              tmo_stop;
    logic              clr_req;
    logic              pending;
    logic              lock;
    logic              disarm;

    wde_regs #(.DATA_W(DATA_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .lock      (lock),
        .disarm    (disarm),
        .pending   (pending),
        .tmo       (tmo),
        .win       (win),
        .irq_en    (irq_en),
        .tmo_start (tmo_start),
        .tmo_stop  (tmo_stop),
        .clr_req   (clr_req),
        .bus_rdata (bus_rdata)
    );

    wde_ctrl #(.DATA_W(DATA_W), .PULSE_LEN(PULSE_LEN)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .tmo        (tmo),
        .win        (win),
        .irq_en     (irq_en),
        .tmo_start  (tmo_start),
        .tmo_stop   (tmo_stop),
        .clr_req    (clr_req),
        .pending    (pending),
        .lock       (lock),
        .disarm     (disarm),
        .peri_rst_n (peri_rst_n),
        .sys_rst_n  (sys_rst_n)
    );

    assign irq = pending;

    // R4: both reset outputs move as one
    p_rst_pair_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (peri_rst_n == sys_rst_n))
        else $error("reset outputs disagree");

endmodule

// File: tb/tb_watchdog_escalator.sv
module tb_watchdog_escalator;

    localparam int CLK_P  = 10;
    localparam int DATA_W = 32;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bus_sel = 1'b0;
    logic              bus_wr = 1'b0;
    logic [3:0]        bus_addr = '0;
    logic [DATA_W-1:0] bus_wdata = '0;
    logic [DATA_W-1:0] bus_rdata;
    logic              irq;
    logic              peri_rst_n;
    logic              sys_rst_n;

    int total = 0;
    int bad = 0;
    int cyc = 0;

    always #(CLK_P/2) clk = ~clk;

    watchdog_escalator dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_sel    (bus_sel),
        .bus_wr     (bus_wr),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .irq        (irq),
        .peri_rst_n (peri_rst_n),
        .sys_rst_n  (sys_rst_n)
    );

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            total++;
            bad++;
            $display("FAIL watchdog (all requirements) actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
        bus_sel   = 1'b1;
        bus_wr    = 1'b1;
        bus_addr  = a;
        bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0;
        bus_wr  = 1'b0;
    endtask

    task automatic bus_read(input logic [3:0] a, output logic [31:0] d);
        bus_sel  = 1'b1;
        bus_wr   = 1'b0;
        bus_addr = a;
        #1;
        d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        wait_n(3);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // Called at the first sample with resets low; measures the pulse length.
    task automatic check_pulse(input string req);
        int n;
        n = 1;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (!sys_rst_n && !peri_rst_n) n++;
            else break;
        end
        chk({req, " pulse length"}, n, 16);
        chk({req, " resets released"}, {30'b0, peri_rst_n, sys_rst_n}, 32'h3);
    endtask

    task automatic t_reset_state();
        logic [31:0] d;
        do_reset();
        chk("R1 irq", {31'b0, irq}, 0);
        chk("R1 resets", {30'b0, peri_rst_n, sys_rst_n}, 32'h3);
        for (int a = 0; a < 16; a += 4) begin
            bus_read(4'(a), d);
            chk("R1 register reads zero", d, 0);
        end
    endtask

    task automatic t_regmap();
        logic [31:0] d;
        do_reset();
        bus_write(4'h4, 32'h0000_1234);
        bus_read(4'h4, d);
        chk("R2 window readback", d, 32'h1234);
        bus_write(4'h8, 32'hFF);
        bus_read(4'h8, d);
        chk("R2 enable bit only", d, 32'h1);
        bus_write(4'h8, 32'h0);
        bus_write(4'h0, 32'hABCD_0000);
        bus_read(4'h0, d);
        chk("R2 timeout readback", d, 32'hABCD_0000);
        bus_read(4'hC, d);
        chk("R2 pending reads zero", d, 0);
        bus_write(4'h0, 32'h0);
        bus_read(4'h0, d);
        chk("R2 timeout cleared by write", d, 0);
    endtask

    task automatic t_direct();
        logic [31:0] d;
        do_reset();
        bus_write(4'h0, 32'd5);
        wait_n(5);
        chk("R3 still high before limit", {30'b0, peri_rst_n, sys_rst_n}, 32'h3);
        wait_n(1);
        chk("R3 both low at T+1", {30'b0, peri_rst_n, sys_rst_n}, 32'h0);
        check_pulse("R4");
        bus_read(4'h0, d);
        chk("R5 timeout disarmed", d, 0);
        bus_read(4'hC, d);
        chk("R5 pending zero", d, 0);
        wait_n(40);
        chk("R5 no second reset", {30'b0, peri_rst_n, sys_rst_n}, 32'h3);
    endtask

    task automatic t_prewarn();
        logic [31:0] d;
        do_reset();
        bus_write(4'h4, 32'd3);
        bus_write(4'h8, 32'd1);
        bus_write(4'h0, 32'd5);
        wait_n(5);
        chk("R6 irq low before limit", {31'b0, irq}, 0);
        wait_n(1);
        chk("R6 irq at T+1", {31'b0, irq}, 1);
        chk("R6 resets high with irq", {30'b0, peri_rst_n, sys_rst_n}, 32'h3);
        bus_read(4'hC, d);
        chk("R2 pending readable", d, 1);
        wait_n(3);
        chk("R7 high inside window", {31'b0, sys_rst_n}, 1);
        wait_n(1);
        chk("R7 reset at W+1", {30'b0, peri_rst_n, sys_rst_n}, 32'h0);
        check_pulse("R7");
        chk("R5 irq cleared after pulse", {31'b0, irq}, 0);
    endtask

    task automatic t_clear();
        do_reset();
        bus_write(4'h4, 32'd3);
        bus_write(4'h8, 32'd1);
        bus_write(4'h0, 32'd5);
        wait_n(6);
        chk("R8 irq raised", {31'b0, irq}, 1);
        bus_write(4'hC, 32'd1);
        chk("R8 irq dropped by clear", {31'b0, irq}, 0);
        wait_n(5);
        chk("R8 irq low during restart", {31'b0, irq}, 0);
        chk("R8 no reset after clear", {31'b0, sys_rst_n}, 1);
        wait_n(1);
        chk("R8 irq again at T+1 after clear", {31'b0, irq}, 1);
        bus_write(4'hC, 32'd1);
        bus_write(4'h0, 32'd0);
        wait_n(50);
        chk("R9 no irq after stop", {31'b0, irq}, 0);
        chk("R9 no reset after stop", {30'b0, peri_rst_n, sys_rst_n}, 32'h3);
    endtask

    task automatic t_rewrite();
        do_reset();
        bus_write(4'h0, 32'd8);
        wait_n(4);
        bus_write(4'h0, 32'd5);
        wait_n(5);
        chk("R10 high before new limit", {31'b0, sys_rst_n}, 1);
        wait_n(1);
        chk("R10 reset at T2+1", {31'b0, sys_rst_n}, 0);
        check_pulse("R10");
        bus_write(4'h0, 32'd8);
        wait_n(4);
        bus_write(4'h0, 32'd8);
        wait_n(3);
        chk("R11 high before original limit", {31'b0, sys_rst_n}, 1);
        wait_n(1);
        chk("R11 reset at original T+1", {31'b0, sys_rst_n}, 0);
        check_pulse("R11");
    endtask

    task automatic t_lock();
        logic [31:0] d;
        do_reset();
        bus_write(4'h4, 32'd3);
        bus_write(4'h0, 32'd4);
        wait_n(5);
        chk("R12 pulse started", {31'b0, sys_rst_n}, 0);
        bus_write(4'h4, 32'd7);
        bus_write(4'h8, 32'd1);
        bus_read(4'h4, d);
        chk("R12 window write ignored", d, 3);
        bus_read(4'h8, d);
        chk("R12 enable write ignored", d, 0);
        for (int i = 0; i < 30; i++) begin
            if (sys_rst_n) break;
            @(negedge clk);
        end
        bus_read(4'h4, d);
        chk("R12 window kept after pulse", d, 3);
    endtask

    initial begin
        t_reset_state();
        t_regmap();
        t_direct();
        t_prewarn();
        t_clear();
        t_rewrite();
        t_lock();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule